// File: doc/BRIEF.md
# Audio Sample Rate Mode Detector

This block watches the frame clock and the master clock of a stereo serial audio link and works out which of three speed modes the link runs in. It counts cycles of a fixed reference clock between rising frame-clock edges to estimate the frame period, then sorts that period into a single, double or quad speed band. A frame period that falls outside every band is reported as unsupported and is never rounded to the nearest band. In a separate counter clocked by the master clock, it counts master clock cycles per frame and checks the result against the set of oversampling ratios that the detected mode allows.

The mode output follows rate changes with no outside command. A new mode only takes effect once it has been seen on several consecutive frames in a row, so one disturbed frame cannot switch the mode. If the frame clock stops, a timeout stands in for the missing frame edge and the block drops to the unsupported state once the debounce count is met. If the master clock stops while the mode is valid, the ratio error flag goes high.

Top module: `spd_rate_detector`

## Requirements
- R1: While reset is high and in the first cycle after it, mode_o reads 0 (none), mode_valid_o reads 0 and ratio_err_o reads 0.
- R2: A frame rate between 4 kHz and 50 kHz gives mode_o = 1 (single speed) and mode_valid_o = 1.
- R3: A frame rate between 84 kHz and 100 kHz gives mode_o = 2 (double speed) and mode_valid_o = 1.
- R4: A frame rate between 170 kHz and 200 kHz gives mode_o = 3 (quad speed) and mode_valid_o = 1.
- R5: A frame rate in either gap (above 50 kHz and below 84 kHz, or above 100 kHz and below 170 kHz) gives mode_o = 0 and mode_valid_o = 0.
- R6: mode_o changes only after DEBOUNCE (default 4) consecutive frame periods have been classified the same way; until then the previous mode and valid flag hold, and moves between modes happen on their own.
- R7: In single speed, master clock counts per frame of 256, 384, 512 and 768 keep ratio_err_o low; any other count sets it.
- R8: In double speed, counts of 128, 192, 256 and 384 keep ratio_err_o low; any other count (512 included) sets it.
- R9: In quad speed, counts of 128 and 192 keep ratio_err_o low; any other count (256 included) sets it.
- R10: A count within RATIO_TOL (default 2) cycles of a legal ratio is accepted; a count 3 away is an error.
- R11: ratio_err_o is low whenever mode_valid_o is low, and ratio_err_o and mode_o change only right after a frame period has been closed.
- R12: With the frame clock stopped, each run of the reference counter to its timeout counts as one unsupported period, so mode_o drops to 0 after DEBOUNCE timeouts and holds before that.
- R13: With the master clock stopped and the mode valid, ratio_err_o goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock of known frequency REF_HZ |
| rst | input | 1 | Synchronous active-high reset, reference domain |
| mclk_i | input | 1 | Master clock from the audio link |
| lrck_i | input | 1 | Frame (left/right) clock from the audio link |
| mode_o | output | 2 | Speed mode: 0 none, 1 single, 2 double, 3 quad |
| mode_valid_o | output | 1 | High when mode_o is not 0 |
| ratio_err_o | output | 1 | Master clock count per frame does not fit the mode |

## Verification
A frame period is closed SYNC_STAGES+1 reference cycles after a rising frame-clock edge, and mode_o moves one cycle after the period that makes the fourth match. ratio_err_o is judged against the master clock count of the period before, because that count crosses clock domains later than the frame event, so a new ratio shows up at the second closed period. The bench therefore plays at least five or six whole frames before it compares an output, samples on the falling reference edge, and for the debounce check samples in the gap between the third and fourth matching periods. Timeout checks wait in whole multiples of the timeout length counted from the last frame edge.

// File: rtl/spd_pkg.sv
package spd_pkg;

    typedef enum logic [1:0] {
        SPD_NONE   = 2'd0,
        SPD_SINGLE = 2'd1,
        SPD_DOUBLE = 2'd2,
        SPD_QUAD   = 2'd3
    } spd_mode_e;

    // Frame rate bands in Hz, inclusive
    localparam int unsigned SINGLE_MIN_HZ = 4000;
    localparam int unsigned SINGLE_MAX_HZ = 50000;
    localparam int unsigned DOUBLE_MIN_HZ = 84000;
    localparam int unsigned DOUBLE_MAX_HZ = 100000;
    localparam int unsigned QUAD_MIN_HZ   = 170000;
    localparam int unsigned QUAD_MAX_HZ   = 200000;

    localparam int unsigned RATIO_SLOTS = 4;

    // Period in reference cycles to speed band
    function automatic spd_mode_e spd_classify(input int unsigned period,
                                               input int unsigned ref_hz);
        spd_mode_e m;
        m = SPD_NONE;
        if (period >= ref_hz / SINGLE_MAX_HZ && period <= ref_hz / SINGLE_MIN_HZ)
            m = SPD_SINGLE;
        else if (period >= ref_hz / DOUBLE_MAX_HZ && period <= ref_hz / DOUBLE_MIN_HZ)
            m = SPD_DOUBLE;
        else if (period >= ref_hz / QUAD_MAX_HZ && period <= ref_hz / QUAD_MIN_HZ)
            m = SPD_QUAD;
        return m;
    endfunction

    // Legal oversampling ratio per mode and slot, 0 marks an unused slot
    function automatic int unsigned spd_legal_ratio(input spd_mode_e m,
                                                    input int unsigned slot);
        int unsigned r;
        r = 0;
        case (m)
            SPD_SINGLE: r = (slot == 0) ? 256 : (slot == 1) ? 384 : (slot == 2) ? 512 : 768;
            SPD_DOUBLE: r = (slot == 0) ? 128 : (slot == 1) ? 192 : (slot == 2) ? 256 : 384;
            SPD_QUAD:   r = (slot == 0) ? 128 : (slot == 1) ? 192 : 0;
            default:    r = 0;
        endcase
        return r;
    endfunction

    function automatic logic spd_ratio_ok(input spd_mode_e m,
                                          input int unsigned cnt,
                                          input int unsigned tol);
        logic ok;
        int unsigned r;
        ok = 1'b0;
        for (int unsigned s = 0; s < RATIO_SLOTS; s++) begin
            r = spd_legal_ratio(m, s);
            if (r != 0 && cnt + tol >= r && cnt <= r + tol)
                ok = 1'b1;
        end
        return ok;
    endfunction

endpackage

// File: rtl/spd_sync.sv
module spd_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) sh[i] <= RST_VAL;
                else     sh[i] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) sh[i] <= RST_VAL;
                else     sh[i] <= sh[i-1];
            end
        end
    end

    assign q_o = sh[STAGES-1];
endmodule

// File: rtl/spd_frame_meter.sv
module spd_frame_meter #(
    parameter int unsigned PER_W       = 15,
    parameter int unsigned TIMEOUT     = 13281,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lrck_i,
    output logic             evt_o,
    output logic [PER_W-1:0] period_o
);
    logic             lrck_s;
    logic             lrck_q;
    logic             armed_q;
    logic [PER_W-1:0] cnt_q;
    logic             rise;

    spd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_lrck_sync (
        .clk (clk),
        .rst (rst),
        .d_i (lrck_i),
        .q_o (lrck_s)
    );

    assign rise = lrck_s & ~lrck_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lrck_q   <= 1'b0;
            armed_q  <= 1'b0;
            cnt_q    <= PER_W'(1);
            evt_o    <= 1'b0;
            period_o <= '0;
        end else begin
            lrck_q <= lrck_s;
            evt_o  <= 1'b0;
            if (rise) begin
                // the first edge after reset or timeout only opens a period
                if (armed_q) begin
                    evt_o    <= 1'b1;
                    period_o <= cnt_q;
                end
                armed_q <= 1'b1;
                cnt_q   <= PER_W'(1);
            end else if (cnt_q >= PER_W'(TIMEOUT)) begin
                evt_o    <= 1'b1;
                period_o <= cnt_q;
                armed_q  <= 1'b0;
                cnt_q    <= PER_W'(1);
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/spd_mclk_counter.sv
module spd_mclk_counter #(
    parameter int unsigned RAT_W       = 11,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mclk_i,
    input  logic             lrck_i,
    output logic             fresh_o,
    output logic [RAT_W-1:0] ratio_o
);
    // master clock domain
    logic             m_rst;
    logic             m_lrck;
    logic             m_lrck_q;
    logic             m_tog;
    logic [RAT_W-1:0] m_cnt;
    logic [RAT_W-1:0] m_cap;

    spd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rst_sync (
        .clk (mclk_i),
        .rst (1'b0),
        .d_i (rst),
        .q_o (m_rst)
    );

    spd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_lrck_sync (
        .clk (mclk_i),
        .rst (m_rst),
        .d_i (lrck_i),
        .q_o (m_lrck)
    );

    always_ff @(posedge mclk_i) begin
        if (m_rst) begin
            m_lrck_q <= 1'b0;
            m_tog    <= 1'b0;
            m_cnt    <= RAT_W'(1);
            m_cap    <= '0;
        end else begin
            m_lrck_q <= m_lrck;
            if (m_lrck && !m_lrck_q) begin
                m_cap <= m_cnt;
                m_cnt <= RAT_W'(1);
                m_tog <= ~m_tog;
            end else if (m_cnt != '1) begin
                m_cnt <= m_cnt + 1'b1;
            end
        end
    end

    // reference domain: the toggle marks a new stable count
    logic tog_s;
    logic tog_q;

    spd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_tog_sync (
        .clk (clk),
        .rst (rst),
        .d_i (m_tog),
        .q_o (tog_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tog_q   <= 1'b0;
            fresh_o <= 1'b0;
            ratio_o <= '0;
        end else begin
            tog_q   <= tog_s;
            fresh_o <= tog_s ^ tog_q;
            if (tog_s ^ tog_q)
                ratio_o <= m_cap;
        end
    end
endmodule

// File: rtl/spd_mode_arbiter.sv
module spd_mode_arbiter
    import spd_pkg::*;
#(
    parameter int unsigned REF_HZ    = 50_000_000,
    parameter int unsigned PER_W     = 15,
    parameter int unsigned RAT_W     = 11,
    parameter int unsigned DEBOUNCE  = 4,
    parameter int unsigned STREAK_W  = 3,
    parameter int unsigned RATIO_TOL = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt_i,
    input  logic [PER_W-1:0] period_i,
    input  logic             fresh_i,
    input  logic [RAT_W-1:0] ratio_i,
    output spd_mode_e        mode_o,
    output logic             ratio_err_o
);
    spd_mode_e            cls;
    spd_mode_e            cand_q;
    spd_mode_e            mode_n;
    logic [STREAK_W-1:0]  streak_q;
    logic [STREAK_W-1:0]  streak_n;
    logic                 have_q;
    logic [RAT_W-1:0]     ratio_q;
    logic                 err_n;

    always_comb begin
        cls      = spd_classify(32'(period_i), REF_HZ);
        streak_n = streak_q;
        mode_n   = mode_o;
        if (cls == cand_q) begin
            if (streak_q < STREAK_W'(DEBOUNCE))
                streak_n = streak_q + 1'b1;
        end else begin
            streak_n = STREAK_W'(1);
        end
        if (streak_n == STREAK_W'(DEBOUNCE))
            mode_n = cls;
        err_n = (mode_n != SPD_NONE) &&
                !(have_q && spd_ratio_ok(mode_n, 32'(ratio_q), RATIO_TOL));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cand_q      <= SPD_NONE;
            streak_q    <= '0;
            mode_o      <= SPD_NONE;
            ratio_err_o <= 1'b0;
            have_q      <= 1'b0;
            ratio_q     <= '0;
        end else begin
            if (fresh_i) begin
                have_q  <= 1'b1;
                ratio_q <= ratio_i;
            end
            if (evt_i) begin
                cand_q      <= cls;
                streak_q    <= streak_n;
                mode_o      <= mode_n;
                ratio_err_o <= err_n;
                if (!fresh_i)
                    have_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/spd_rate_detector.sv
module spd_rate_detector
    import spd_pkg::*;
#(
    parameter int unsigned REF_HZ      = 50_000_000,
    parameter int unsigned DEBOUNCE    = 4,
    parameter int unsigned RATIO_TOL   = 2,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned RAT_W       = 11
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mclk_i,
    input  logic       lrck_i,
    output logic [1:0] mode_o,
    output logic       mode_valid_o,
    output logic       ratio_err_o
);
    localparam int unsigned SLOW_LIMIT = REF_HZ / SINGLE_MIN_HZ;
    localparam int unsigned TIMEOUT    = SLOW_LIMIT + SLOW_LIMIT / 16;
    localparam int unsigned PER_W      = $clog2(TIMEOUT + 1);
    localparam int unsigned STREAK_W   = $clog2(DEBOUNCE + 1);

    logic             frame_evt;
    logic [PER_W-1:0] frame_period;
    logic             ratio_fresh;
    logic [RAT_W-1:0] ratio_cnt;
    spd_mode_e        mode_q;

    spd_frame_meter #(
        .PER_W       (PER_W),
        .TIMEOUT     (TIMEOUT),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_meter (
        .clk      (clk),
        .rst      (rst),
        .lrck_i   (lrck_i),
        .evt_o    (frame_evt),
        .period_o (frame_period)
    );

    spd_mclk_counter #(
        .RAT_W       (RAT_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_mcnt (
        .clk     (clk),
        .rst     (rst),
        .mclk_i  (mclk_i),
        .lrck_i  (lrck_i),
        .fresh_o (ratio_fresh),
        .ratio_o (ratio_cnt)
    );

    spd_mode_arbiter #(
        .REF_HZ    (REF_HZ),
        .PER_W     (PER_W),
        .RAT_W     (RAT_W),
        .DEBOUNCE  (DEBOUNCE),
        .STREAK_W  (STREAK_W),
        .RATIO_TOL (RATIO_TOL)
    ) u_arb (
        .clk         (clk),
        .rst         (rst),
        .evt_i       (frame_evt),
        .period_i    (frame_period),
        .fresh_i     (ratio_fresh),
        .ratio_i     (ratio_cnt),
        .mode_o      (mode_q),
        .ratio_err_o (ratio_err_o)
    );

    assign mode_o       = mode_q;
    assign mode_valid_o = (mode_q != SPD_NONE);
endmodule

// File: rtl/spd_rate_detector_chk.sv
module spd_rate_detector_chk #(
    parameter int unsigned DEBOUNCE = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       evt_i,
    input logic [1:0] mode_i,
    input logic       valid_i,
    input logic       err_i
);
    logic [1:0] mode_prev;
    logic [7:0] evcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_prev <= 2'd0;
            evcnt     <= 8'd0;
        end else begin
            mode_prev <= mode_i;
            if (mode_i != mode_prev)
                evcnt <= 8'd0;
            else if (evt_i && evcnt != 8'hff)
                evcnt <= evcnt + 8'd1;
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (mode_i == 2'd0 && !valid_i && !err_i));

    p_mode_on_period_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode_i) |-> $past(evt_i));

    p_mode_needs_streak_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode_i) |-> (32'(evcnt) + 1 >= DEBOUNCE));

    p_err_on_period_r11: assert property (@(posedge clk) disable iff (rst)
        !$stable(err_i) |-> $past(evt_i));

    p_err_needs_mode_r11: assert property (@(posedge clk) disable iff (rst)
        !valid_i |-> !err_i);
endmodule

bind spd_rate_detector spd_rate_detector_chk #(.DEBOUNCE(DEBOUNCE)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .evt_i   (frame_evt),
    .mode_i  (mode_o),
    .valid_i (mode_valid_o),
    .err_i   (ratio_err_o)
);

// File: tb/spd_rate_detector_tb.sv
`timescale 1ns/1ps
module spd_rate_detector_tb;
    localparam real CLK_PERIOD = 20.0;
    localparam int  TIMEOUT_CYC = 12500 + 12500 / 16;
    localparam int  WATCHDOG = 195000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mclk = 1'b0;
    logic lrck = 1'b0;
    logic [1:0] mode;
    logic valid;
    logic rerr;

    real mclk_half = 10.0;
    bit  mclk_run = 1'b1;
    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    spd_rate_detector u_dut (
        .clk          (clk),
        .rst          (rst),
        .mclk_i       (mclk),
        .lrck_i       (lrck),
        .mode_o       (mode),
        .mode_valid_o (valid),
        .ratio_err_o  (rerr)
    );

    always #(CLK_PERIOD / 2.0) clk = ~clk;

    always begin
        if (mclk_run) begin
            #(mclk_half) mclk = ~mclk;
        end else begin
            #(CLK_PERIOD);
        end
    end

    function automatic int exp_mode(input real fs);
        if (fs >= 4000.0 && fs <= 50000.0) return 1;
        if (fs >= 84000.0 && fs <= 100000.0) return 2;
        if (fs >= 170000.0 && fs <= 200000.0) return 3;
        return 0;
    endfunction

    function automatic int exp_err(input int m, input int r);
        int legal[4];
        int n;
        if (m == 0) return 0;
        if (m == 1) begin legal = '{256, 384, 512, 768}; n = 4; end
        else if (m == 2) begin legal = '{128, 192, 256, 384}; n = 4; end
        else begin legal = '{128, 192, 0, 0}; n = 2; end
        for (int i = 0; i < n; i++)
            if (r >= legal[i] - 2 && r <= legal[i] + 2) return 0;
        return 1;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // frames derived from the master clock, lrck moves on falling mclk edges
    task automatic play(input real fs, input int ratio, input int n);
        int h;
        mclk_half = 1.0e9 / (fs * ratio) / 2.0;
        h = ratio / 2;
        @(negedge mclk);
        for (int f = 0; f < n; f++) begin
            lrck = 1'b1;
            repeat (h) @(negedge mclk);
            lrck = 1'b0;
            repeat (ratio - h) @(negedge mclk);
        end
    endtask

    task automatic play_free(input real fs, input int n);
        real half;
        half = 1.0e9 / fs / 2.0;
        for (int f = 0; f < n; f++) begin
            lrck = 1'b1;
            #(half);
            lrck = 1'b0;
            #(half);
        end
    endtask

    task automatic expect_out(input string req, input int m, input int e);
        @(negedge clk);
        check(req, "mode", int'(mode), m);
        check(req, "valid", int'(valid), (m != 0) ? 1 : 0);
        check(req, "ratio_err", int'(rerr), e);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int m;
        int r;
        int off;
        real fs;
        int offs[6];
        offs = '{0, 1, -2, 2, -3, 5};
        void'($urandom(32'd4242));

        // R1: reset state
        repeat (20) @(posedge clk);
        @(negedge clk);
        check("R1", "mode in reset", int'(mode), 0);
        check("R1", "err in reset", int'(rerr), 0);
        rst = 1'b0;
        expect_out("R1", 0, 0);

        // R2 / R7: single speed, legal ratio
        play(48000.0, 256, 8);
        expect_out("R2", 1, 0);

        // R6: three matching double periods keep the old mode
        play(96000.0, 256, 4);
        @(negedge clk);
        check("R6", "mode held after 3 periods", int'(mode), 1);
        play(96000.0, 256, 1);
        @(negedge clk);
        check("R6", "mode taken on 4th period", int'(mode), 2);
        play(96000.0, 256, 5);
        expect_out("R3", 2, 0);

        // R8: double speed ratios
        play(96000.0, 128, 5);
        expect_out("R8", 2, 0);
        play(96000.0, 512, 5);
        expect_out("R8", 2, 1);

        // R4 / R9: quad speed ratios
        play(192000.0, 192, 7);
        expect_out("R4", 3, 0);
        play(192000.0, 256, 5);
        expect_out("R9", 3, 1);

        // R7: single speed ratios
        play(48000.0, 768, 6);
        expect_out("R7", 1, 0);
        play(48000.0, 128, 5);
        expect_out("R7", 1, 1);

        // R10: tolerance edges
        play(48000.0, 258, 5);
        expect_out("R10", 1, 0);
        play(48000.0, 259, 5);
        expect_out("R10", 1, 1);
        play(48000.0, 254, 5);
        expect_out("R10", 1, 0);

        // R5 / R11: gap rates are unsupported, no ratio error
        play(70000.0, 256, 6);
        expect_out("R5", 0, 0);
        play(96000.0, 256, 6);
        play(130000.0, 128, 6);
        expect_out("R5", 0, 0);

        // R13: master clock stopped while valid
        play(96000.0, 256, 6);
        expect_out("R3", 2, 0);
        mclk_run = 1'b0;
        play_free(96000.0, 6);
        expect_out("R13", 2, 1);
        mclk_run = 1'b1;

        // R12: frame clock stopped, timeouts count as unsupported periods
        repeat (3 * TIMEOUT_CYC + 100) @(posedge clk);
        @(negedge clk);
        check("R12", "mode held after 3 timeouts", int'(mode), 2);
        repeat (TIMEOUT_CYC) @(posedge clk);
        expect_out("R12", 0, 0);

        // random trials over bands and ratios
        for (int t = 0; t < 5; t++) begin
            m = int'($urandom % 3);
            if (m == 0) fs = 44000.0 + real'($urandom % 4000);
            else if (m == 1) fs = 86000.0 + real'($urandom % 12000);
            else fs = 172000.0 + real'($urandom % 26000);
            if (m == 2) r = ($urandom % 2 == 0) ? 128 : 192;
            else if (m == 1) r = 128 << ($urandom % 2) + (($urandom % 2) * 64);
            else r = 256 + 128 * int'($urandom % 4);
            if (m == 0 && r == 640) r = 768;
            if (m == 1 && r > 384) r = 384;
            off = offs[$urandom % 6];
            r = r + off;
            play(fs, r, 6);
            if (m == 0) expect_out("R7", exp_mode(fs), exp_err(exp_mode(fs), r));
            else if (m == 1) expect_out("R8", exp_mode(fs), exp_err(exp_mode(fs), r));
            else expect_out("R9", exp_mode(fs), exp_err(exp_mode(fs), r));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule